// File: doc/BRIEF.md
# Up/Down Timer Counter Core

This block is the counting heart of a general-purpose timer. It holds a counter that steps once per prescaled tick while the timer runs, and a programmable period that sets where the count turns around or wraps. A two-bit mode selects either single-direction counting, up or down, or one of three alternating (center-aligned) modes. In the alternating modes the count climbs from zero to the period and falls back again. The three alternating modes differ only in which turnaround raises the update event.

Each update event is a one-cycle pulse. It sets a sticky flag and can raise a request strobe. It also moves a pending period into the active period when buffering is on, and it can stop the timer in one-shot operation. Update events come from the counter itself. A software trigger and a trigger from a slave controller can also cause one, and a control bit can turn these two sources off. A separate suppress bit blocks every update event while leaving the counting untouched. An elaboration parameter picks a 16-bit or a 32-bit counter and period.

All pins are plain control and status levels or single-cycle strobes. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `tick_counter_core`

## Requirements
- R1: After reset, the count is 0, the direction output is 0 (up), the update pulse, the request strobe and the flag are 0, and `running` equals `tmr_en`.
- R2: The count changes only on a clock edge where `running` and `cnt_tick` are both 1, or when a recognised trigger reinitialises it. `running` is `tmr_en` AND NOT a one-shot halt.
- R3: In mode 2'b00 with `dir_down`=0, the count steps up by one. At a tick where the count is greater than or equal to the period, it goes to 0 and raises an update event. With `dir_down`=1, it steps down by one, and at a tick from 0 it loads the period and raises an update event.
- R4: In mode 2'b01, the count rises from 0 to the period, then falls to 0, then rises again. The direction output is 1 while falling. An update event is raised only at the bottom turnaround: a tick from 0 while falling goes to 1 and turns upward.
- R5: Mode 2'b10 counts in the same alternating way. An update event is raised only at the top turnaround: a tick at the period while rising goes to period-1 and turns downward.
- R6: Mode 2'b11 counts in the same alternating way and raises an update event at both turnarounds.
- R7: With `prd_buf_en`=1, a written period takes effect only at the next update event.
- R8: With `prd_buf_en`=0, a written period is used from the next cycle. A count already above the new period wraps at the next tick.
- R9: With `one_shot`=1, an update event drops `running` to 0. It stays 0 until `tmr_en` has been 0 for at least one clock edge.
- R10: With `hw_src_only`=0, a pulse on `sw_upd` or `slave_upd` reinitialises the count (to 0 when counting up, to the period when counting down) and raises an update event. With `hw_src_only`=1, both triggers have no effect.
- R11: While `upd_block`=1, no update event is raised. There is no pulse, no flag set, no period load and no one-shot halt, but counting and wrapping go on.
- R12: `ovf_flag` is set by an update event and stays set until `flag_clr` is pulsed. An event in the same cycle as `flag_clr` leaves the flag set.
- R13: `req_strobe` pulses together with `upd_pulse` when `req_en`=1, and stays 0 when `req_en`=0.
- R14: With `PLUS_MODE`=1, the counter and the period are 32 bits wide. A period above 65535 is loaded and counted down from exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_en | input | 1 | Timer enable |
| mode | input | 2 | Counting mode: 00 one-way, 01 event at bottom, 10 event at top, 11 both |
| dir_down | input | 1 | One-way direction: 0 up, 1 down |
| prd_buf_en | input | 1 | Hold written periods until the next update event |
| one_shot | input | 1 | Stop at the next update event |
| hw_src_only | input | 1 | Only counter turnarounds raise update events |
| upd_block | input | 1 | Suppress all update events |
| req_en | input | 1 | Let update events raise the request strobe |
| period_val | input | W | Period value to write |
| period_wr | input | 1 | Write strobe for `period_val` |
| sw_upd | input | 1 | Software update trigger |
| slave_upd | input | 1 | Slave-controller update trigger |
| cnt_tick | input | 1 | Prescaled count-enable tick |
| flag_clr | input | 1 | Clear the update flag |
| count | output | W | Counter value |
| count_down | output | 1 | Current count direction, 1 = down |
| upd_pulse | output | 1 | One-cycle update event |
| ovf_flag | output | 1 | Sticky update flag |
| req_strobe | output | 1 | One-cycle request strobe |
| running | output | 1 | Counter is enabled |

## Verification
The bench sweeps every mode and direction over several small periods, for three full cycles each. It predicts each count and event from modular arithmetic. A design that placed the turnaround one count early or late, or flagged the wrong turnaround, shows a wrong count or a stray pulse within one period. Directed cases cover the remaining boundaries. A period shrunk below the running count must wrap at once when unbuffered, and must be held back until the wrap when buffered. A one-shot must halt exactly at the wrap. Triggers must be inert in hardware-only mode and must reload the period when counting down. A clear that coincides with an event must lose to the event.

// File: rtl/tmr_core_pkg.sv
package tmr_core_pkg;
  typedef enum logic [1:0] {
    CM_ONEWAY   = 2'b00,
    CM_CTR_FALL = 2'b01,
    CM_CTR_RISE = 2'b10,
    CM_CTR_BOTH = 2'b11
  } cnt_mode_e;

  typedef struct packed {
    cnt_mode_e mode;
    logic      one_shot;
    logic      hw_only;
    logic      upd_block;
  } evt_cfg_t;
endpackage

// File: rtl/period_store.sv
module period_store #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wr_val,
  input  logic         buf_en,
  input  logic         load,
  output logic [W-1:0] prd_eff,
  output logic [W-1:0] prd_next
);
  logic [W-1:0] pend_q;
  logic [W-1:0] act_q;

  // Pending period always tracks the latest write.
  always_ff @(posedge clk) begin
    if (!rst_n)  pend_q <= '0;
    else if (wr) pend_q <= wr_val;
  end

  // Active period follows the pending one at an update, or continuously
  // while buffering is off so that it is never stale.
  always_ff @(posedge clk) begin
    if (!rst_n)                act_q <= '0;
    else if (load || !buf_en)  act_q <= pend_q;
  end

  assign prd_eff  = buf_en ? act_q : pend_q;
  assign prd_next = (buf_en && !load) ? act_q : pend_q;
endmodule

// File: rtl/count_engine.sv
module count_engine
  import tmr_core_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  cnt_mode_e    mode,
  input  logic         cfg_dn,
  input  logic [W-1:0] prd,
  input  logic         reinit,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] cnt,
  output logic         dn,
  output logic         ev_top,
  output logic         ev_bot
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic         dn_q;
  logic         alt;
  logic         dn_cur;
  logic         step;
  logic         at_top;
  logic         at_bot;
  logic [W-1:0] top_turn;
  logic [W-1:0] bot_turn;

  assign alt      = (mode != CM_ONEWAY);
  assign dn_cur   = alt ? dn_q : cfg_dn;
  assign step     = run && tick && !reinit;
  assign at_top   = !dn_cur && (cnt_q >= prd);
  assign at_bot   = dn_cur && (cnt_q == '0);
  assign top_turn = (prd == '0) ? '0 : prd - ONE;
  assign bot_turn = (prd == '0) ? '0 : ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (reinit) begin
      cnt_q <= dn_cur ? reload_val : '0;
    end else if (step) begin
      if (!alt) begin
        if (!dn_cur) cnt_q <= at_top ? '0 : cnt_q + ONE;
        else         cnt_q <= at_bot ? prd : cnt_q - ONE;
      end else begin
        if (!dn_cur) cnt_q <= at_top ? top_turn : cnt_q + ONE;
        else         cnt_q <= at_bot ? bot_turn : cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               dn_q <= 1'b0;
    else if (!alt)            dn_q <= cfg_dn;
    else if (step && at_top)  dn_q <= 1'b1;
    else if (step && at_bot)  dn_q <= 1'b0;
  end

  assign cnt    = cnt_q;
  assign dn     = dn_cur;
  assign ev_top = step && at_top;
  assign ev_bot = step && at_bot;
endmodule

// File: rtl/event_ctrl.sv
module event_ctrl
  import tmr_core_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  evt_cfg_t cfg,
  input  logic     tmr_en,
  input  logic     ev_top,
  input  logic     ev_bot,
  input  logic     sw_upd,
  input  logic     slave_upd,
  input  logic     flag_clr,
  input  logic     req_en,
  output logic     fire,
  output logic     reinit,
  output logic     running,
  output logic     upd_pulse,
  output logic     ovf_flag,
  output logic     req_strobe
);
  logic hw_ev;
  logic halted_q;
  logic pulse_q;
  logic flag_q;
  logic req_q;

  always_comb begin
    unique case (cfg.mode)
      CM_CTR_FALL: hw_ev = ev_bot;
      CM_CTR_RISE: hw_ev = ev_top;
      default:     hw_ev = ev_top || ev_bot;
    endcase
  end

  assign reinit = !cfg.hw_only && (sw_upd || slave_upd);
  assign fire   = !cfg.upd_block && (hw_ev || reinit);

  always_ff @(posedge clk) begin
    if (!rst_n)                     halted_q <= 1'b0;
    else if (!tmr_en)               halted_q <= 1'b0;
    else if (fire && cfg.one_shot)  halted_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      pulse_q <= fire;
      req_q   <= fire && req_en;
      flag_q  <= fire || (flag_q && !flag_clr);
    end
  end

  assign running    = tmr_en && !halted_q;
  assign upd_pulse  = pulse_q;
  assign ovf_flag   = flag_q;
  assign req_strobe = req_q;
endmodule

// File: rtl/tick_counter_core.sv
module tick_counter_core
  import tmr_core_pkg::*;
#(
  parameter bit PLUS_MODE = 1'b0,
  localparam int W = PLUS_MODE ? 32 : 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tmr_en,
  input  logic [1:0]   mode,
  input  logic         dir_down,
  input  logic         prd_buf_en,
  input  logic         one_shot,
  input  logic         hw_src_only,
  input  logic         upd_block,
  input  logic         req_en,
  input  logic [W-1:0] period_val,
  input  logic         period_wr,
  input  logic         sw_upd,
  input  logic         slave_upd,
  input  logic         cnt_tick,
  input  logic         flag_clr,
  output logic [W-1:0] count,
  output logic         count_down,
  output logic         upd_pulse,
  output logic         ovf_flag,
  output logic         req_strobe,
  output logic         running
);
  evt_cfg_t     cfg;
  logic [W-1:0] prd_eff;
  logic [W-1:0] prd_next;
  logic         fire;
  logic         reinit;
  logic         ev_top;
  logic         ev_bot;

  assign cfg = '{mode: cnt_mode_e'(mode), one_shot: one_shot,
                 hw_only: hw_src_only, upd_block: upd_block};

  period_store #(.W(W)) u_prd (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (period_wr),
    .wr_val   (period_val),
    .buf_en   (prd_buf_en),
    .load     (fire),
    .prd_eff  (prd_eff),
    .prd_next (prd_next)
  );

  count_engine #(.W(W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (running),
    .tick       (cnt_tick),
    .mode       (cfg.mode),
    .cfg_dn     (dir_down),
    .prd        (prd_eff),
    .reinit     (reinit),
    .reload_val (prd_next),
    .cnt        (count),
    .dn         (count_down),
    .ev_top     (ev_top),
    .ev_bot     (ev_bot)
  );

  event_ctrl u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (cfg),
    .tmr_en     (tmr_en),
    .ev_top     (ev_top),
    .ev_bot     (ev_bot),
    .sw_upd     (sw_upd),
    .slave_upd  (slave_upd),
    .flag_clr   (flag_clr),
    .req_en     (req_en),
    .fire       (fire),
    .reinit     (reinit),
    .running    (running),
    .upd_pulse  (upd_pulse),
    .ovf_flag   (ovf_flag),
    .req_strobe (req_strobe)
  );
endmodule

// File: rtl/tick_counter_chk.sv
module tick_counter_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tmr_en,
  input logic [1:0]   mode,
  input logic         one_shot,
  input logic         hw_src_only,
  input logic         upd_block,
  input logic         sw_upd,
  input logic         slave_upd,
  input logic [W-1:0] count,
  input logic         count_down,
  input logic         upd_pulse,
  input logic         ovf_flag,
  input logic         req_strobe,
  input logic         running
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!running && !sw_upd && !slave_upd) |-> $stable(count)); // R2

  AST_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pulse && $past(hw_src_only) && $past(mode) == 2'b01 && mode == 2'b01) |-> !count_down); // R4

  AST_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pulse && $past(hw_src_only) && $past(mode) == 2'b10 && mode == 2'b10) |-> count_down); // R5

  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pulse && $past(one_shot) && $past(tmr_en) && tmr_en) |-> !running); // R9

  AST_NO_PULSE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    upd_block |=> !upd_pulse); // R11

  AST_FLAG_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |-> ovf_flag); // R12

  AST_REQ_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_strobe |-> upd_pulse); // R13
endmodule

bind tick_counter_core tick_counter_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tmr_en      (tmr_en),
  .mode        (mode),
  .one_shot    (one_shot),
  .hw_src_only (hw_src_only),
  .upd_block   (upd_block),
  .sw_upd      (sw_upd),
  .slave_upd   (slave_upd),
  .count       (count),
  .count_down  (count_down),
  .upd_pulse   (upd_pulse),
  .ovf_flag    (ovf_flag),
  .req_strobe  (req_strobe),
  .running     (running)
);

// File: tb/tick_counter_core_tb.sv
module tick_counter_core_tb;
  logic        clk = 1'b0;
  logic        rst_n, tmr_en, dir_down, prd_buf_en, one_shot, hw_src_only;
  logic        upd_block, req_en, period_wr, sw_upd, slave_upd, cnt_tick, flag_clr;
  logic [1:0]  mode;
  logic [15:0] period_val;
  logic [31:0] period_val_w;
  logic [15:0] count;
  logic [31:0] count_w;
  logic        count_down, upd_pulse, ovf_flag, req_strobe, running;
  logic        dn_w, pulse_w, flag_w, req_w, run_w;
  int          total = 0;
  int          bad = 0;

  always #5 clk = ~clk;

  tick_counter_core u_dut (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .mode(mode), .dir_down(dir_down),
    .prd_buf_en(prd_buf_en), .one_shot(one_shot), .hw_src_only(hw_src_only),
    .upd_block(upd_block), .req_en(req_en), .period_val(period_val),
    .period_wr(period_wr), .sw_upd(sw_upd), .slave_upd(slave_upd),
    .cnt_tick(cnt_tick), .flag_clr(flag_clr), .count(count),
    .count_down(count_down), .upd_pulse(upd_pulse), .ovf_flag(ovf_flag),
    .req_strobe(req_strobe), .running(running));

  tick_counter_core #(.PLUS_MODE(1'b1)) u_dut_w (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .mode(mode), .dir_down(dir_down),
    .prd_buf_en(prd_buf_en), .one_shot(one_shot), .hw_src_only(hw_src_only),
    .upd_block(upd_block), .req_en(req_en), .period_val(period_val_w),
    .period_wr(period_wr), .sw_upd(sw_upd), .slave_upd(slave_upd),
    .cnt_tick(cnt_tick), .flag_clr(flag_clr), .count(count_w),
    .count_down(dn_w), .upd_pulse(pulse_w), .ovf_flag(flag_w),
    .req_strobe(req_w), .running(run_w));

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic do_reset();
    rst_n = 1'b0; tmr_en = 1'b0; mode = 2'b00; dir_down = 1'b0;
    prd_buf_en = 1'b0; one_shot = 1'b0; hw_src_only = 1'b1; upd_block = 1'b0;
    req_en = 1'b0; period_val = '0; period_val_w = '0; period_wr = 1'b0;
    sw_upd = 1'b0; slave_upd = 1'b0; cnt_tick = 1'b0; flag_clr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_period(input int p);
    period_val = p[15:0]; period_val_w = p; period_wr = 1'b1;
    @(negedge clk);
    period_wr = 1'b0;
  endtask

  task automatic step();
    cnt_tick = 1'b1;
    @(negedge clk);
    cnt_tick = 1'b0;
  endtask

  task automatic pulse_sw();
    sw_upd = 1'b1;
    @(negedge clk);
    sw_upd = 1'b0;
  endtask

  task automatic pulse_slave();
    slave_upd = 1'b1;
    @(negedge clk);
    slave_upd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    tmr_en = 1'b1;
    #1;
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 dir", count_down, 0);
    chk("R1 pulse", upd_pulse, 0);
    chk("R1 flag", ovf_flag, 0);
    chk("R1 req", req_strobe, 0);
    chk("R1 running", running, 1);

    // Sweep: mode 0 up, mode 0 down, and the three alternating modes (R3-R6 below)
    for (int cfgsel = 0; cfgsel < 5; cfgsel++) begin
      for (int p = 1; p <= 4; p++) begin
        do_reset();
        tmr_en = 1'b1;
        mode = (cfgsel < 2) ? 2'b00 : 2'(cfgsel - 1);
        dir_down = (cfgsel == 1);
        set_period(p);
        for (int n = 1; n <= 3 * 2 * p + 2; n++) begin
          int  ec;
          int  ed;
          bit  ee, top, bot;
          step();
          if (cfgsel == 0) begin
            ec = n % (p + 1); ee = (n % (p + 1) == 0); ed = 0;
            chk("R3 up count", count, ec);
            chk("R3 up event", upd_pulse, ee);
          end else if (cfgsel == 1) begin
            ec = ((p + 1) - n % (p + 1)) % (p + 1); ee = (n % (p + 1) == 1); ed = 1;
            chk("R3 down count", count, ec);
            chk("R3 down event", upd_pulse, ee);
          end else begin
            int m;
            m   = n % (2 * p);
            ec  = (m <= p) ? m : 2 * p - m;
            ed  = (m > p || m == 0) ? 1 : 0;
            top = ((n - 1) % (2 * p) == p);
            bot = (n > 1) && (n % (2 * p) == 1);
            if (cfgsel == 2) begin
              ee = bot;
              chk("R4 count", count, ec); chk("R4 dir", count_down, ed);
              chk("R4 event", upd_pulse, ee);
            end else if (cfgsel == 3) begin
              ee = top;
              chk("R5 count", count, ec); chk("R5 dir", count_down, ed);
              chk("R5 event", upd_pulse, ee);
            end else begin
              ee = top || bot;
              chk("R6 count", count, ec); chk("R6 dir", count_down, ed);
              chk("R6 event", upd_pulse, ee);
            end
          end
        end
      end
    end

    // R2: no tick or not enabled -> no change
    do_reset(); tmr_en = 1'b1; set_period(3);
    repeat (3) @(negedge clk);
    chk("R2 no tick", count, 0);
    step(); chk("R2 ticked", count, 1);
    tmr_en = 1'b0;
    step(); step();
    chk("R2 disabled", count, 1);
    chk("R2 running low", running, 0);

    // R7: buffered period
    do_reset(); tmr_en = 1'b1; prd_buf_en = 1'b1; hw_src_only = 1'b0;
    set_period(4);
    pulse_sw();
    chk("R7 load event", upd_pulse, 1); chk("R7 reinit", count, 0);
    step(); chk("R7 count", count, 1);
    set_period(2);
    step(); chk("R7 old prd a", count, 2);
    step(); chk("R7 old prd b", count, 3);
    step(); chk("R7 old prd c", count, 4);
    step(); chk("R7 wrap old", count, 0); chk("R7 wrap event", upd_pulse, 1);
    step(); step(); chk("R7 new prd", count, 2);
    step(); chk("R7 wrap new", count, 0); chk("R7 wrap new event", upd_pulse, 1);

    // R8: unbuffered period shrink
    do_reset(); tmr_en = 1'b1; set_period(5);
    repeat (3) step();
    chk("R8 before", count, 3);
    set_period(2);
    step(); chk("R8 wrap now", count, 0); chk("R8 event", upd_pulse, 1);

    // R9: one-shot
    do_reset(); tmr_en = 1'b1; one_shot = 1'b1; set_period(2);
    step(); step(); step();
    chk("R9 wrap", count, 0); chk("R9 event", upd_pulse, 1);
    chk("R9 halted", running, 0);
    step(); chk("R9 stays", count, 0);
    tmr_en = 1'b0; @(negedge clk); tmr_en = 1'b1; #1;
    chk("R9 rearmed", running, 1);
    step(); chk("R9 counts again", count, 1);

    // R10: trigger sources
    do_reset(); tmr_en = 1'b1; set_period(3);
    step(); step();
    pulse_sw(); chk("R10 sw ignored", count, 2); chk("R10 sw no event", upd_pulse, 0);
    pulse_slave(); chk("R10 slave ignored", count, 2); chk("R10 slave no event", upd_pulse, 0);
    hw_src_only = 1'b0;
    pulse_slave(); chk("R10 slave reinit", count, 0); chk("R10 slave event", upd_pulse, 1);
    dir_down = 1'b1;
    step(); chk("R10 down reload", count, 3);
    step(); chk("R10 down step", count, 2);
    pulse_sw(); chk("R10 sw reinit down", count, 3); chk("R10 sw event", upd_pulse, 1);

    // R11: suppression, then R12 flag
    do_reset(); tmr_en = 1'b1; upd_block = 1'b1; one_shot = 1'b1; set_period(2);
    step(); step(); step();
    chk("R11 wraps", count, 0); chk("R11 no pulse", upd_pulse, 0);
    chk("R11 no flag", ovf_flag, 0); chk("R11 no halt", running, 1);
    upd_block = 1'b0; one_shot = 1'b0;
    step(); step(); step();
    chk("R12 flag set", ovf_flag, 1);
    step(); chk("R12 flag held", ovf_flag, 1);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    chk("R12 flag cleared", ovf_flag, 0);
    step();
    flag_clr = 1'b1; step(); flag_clr = 1'b0;
    chk("R12 set wins", ovf_flag, 1);

    // R13: request strobe
    do_reset(); tmr_en = 1'b1; req_en = 1'b1; set_period(1);
    step(); chk("R13 no req", req_strobe, 0);
    step(); chk("R13 req", req_strobe, 1);
    req_en = 1'b0;
    step(); step(); chk("R13 req off", req_strobe, 0); chk("R13 pulse still", upd_pulse, 1);

    // R14: wide counter
    do_reset(); tmr_en = 1'b1; dir_down = 1'b1; set_period(70000);
    step(); chk("R14 wide reload", count_w, 70000);
    step(); chk("R14 wide step", count_w, 69999);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule